// File: doc/BRIEF.md
# Multi-Port Shared Register File with Write-Collision Resolution

This block is a small register array shared by several requesters. Every requester port may issue one read or one write in each clock cycle, and nothing stalls. When two or more ports write the same cell in one cycle, the collision is settled by a policy chosen on the `mode_i` input. The policy may demand that all writers agree. It may pick a single winner by port rank. It may also fold all the written values into one result: a wrapping sum, a bitwise AND or an unsigned maximum.

Reads are combinational from the stored contents. A read therefore sees the value from before the current cycle's writes, and the settled write shows up from the next cycle on. Two optional checks can be switched on at run time. One reports when several ports write one cell in a cycle. The other reports when several ports read one cell in a cycle. Both flags are registered and appear one cycle after the offending request. A disagreement under the agreement policy sets a sticky error that only reset clears.

Top module: `cwr_crcw_mem`

## Requirements
- R1: While reset is asserted and after its release, every cell reads as zero and `agree_err_o`, `wr_clash_o` and `rd_clash_o` are low. Reset asserts asynchronously and releases in step with the clock two edges later.
- R2: A port reads when its valid is 1 and its write enable is 0. Its read data equals the cell at its address before this cycle's writes. Any number of ports may read one cell together. A port that is not reading returns zero. A cycle without writes leaves every cell unchanged.
- R3: Writes to different addresses in one cycle all take effect, each visible from the next cycle.
- R4: With `mode_i`=0 (agreement), colliding writers that present equal data store that data. If any of them differ, the cell keeps its old value and `agree_err_o` rises on the next cycle and stays high until reset.
- R5: With `mode_i`=1 (single winner), the active writer with the lowest port index is stored and the others are dropped.
- R6: With `mode_i`=2 (rank), and for the reserved codes 6 and 7, the writer with the lowest port index is stored.
- R7: With `mode_i`=3, the cell receives the sum of all written values modulo 2^DW.
- R8: With `mode_i`=4, the cell receives the bitwise AND of all written values.
- R9: With `mode_i`=5, the cell receives the unsigned maximum of all written values.
- R10: `wr_clash_o` is high in the cycle after one in which `excl_wr_i` was 1 and at least one cell had two or more writers. Otherwise it is low.
- R11: `rd_clash_o` is high in the cycle after one in which `excl_rd_i` was 1 and at least one cell had two or more readers. Otherwise it is low.
- R12: Collisions under modes other than 0 never set `agree_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Collision policy code (see R4 to R9) |
| excl_rd_i | input | 1 | Enables the shared-read check |
| excl_wr_i | input | 1 | Enables the shared-write check |
| req_vld_i | input | NP | Per-port request valid |
| req_we_i | input | NP | Per-port write enable (0 = read) |
| req_addr_i | input | NP*AW | Per-port cell address, port p at bits p*AW upward |
| req_wdata_i | input | NP*DW | Per-port write data, port p at bits p*DW upward |
| rsp_rdata_o | output | NP*DW | Per-port read data, port p at bits p*DW upward |
| agree_err_o | output | 1 | Sticky agreement-violation error |
| wr_clash_o | output | 1 | Registered shared-write flag |
| rd_clash_o | output | 1 | Registered shared-read flag |

## Verification
The assertions assume that `mode_i`, `excl_rd_i` and `excl_wr_i` are driven to known values in every cycle after reset. They also assume that the request inputs stay low while reset is held, so the first sampled past values are idle requests. The bench changes every input only on the falling clock edge. It keeps all requests cleared around each reset. Its addresses always fall inside the array, and its random phase draws them from a narrow range so that collisions are frequent under every policy code.

// File: rtl/cwr_pkg.sv
package cwr_pkg;

  // Policy codes applied when several ports write one cell in a cycle
  typedef enum logic [2:0] {
    POL_AGREE = 3'd0,
    POL_ANY   = 3'd1,
    POL_RANK  = 3'd2,
    POL_SUM   = 3'd3,
    POL_AND   = 3'd4,
    POL_MAX   = 3'd5,
    POL_RSV6  = 3'd6,
    POL_RSV7  = 3'd7
  } policy_e;

endpackage

// File: rtl/cwr_rst_sync.sv
module cwr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];

endmodule

// File: rtl/cwr_cell_resolve.sv
module cwr_cell_resolve
  import cwr_pkg::*;
#(
  parameter int NP = 4,
  parameter int DW = 8
) (
  input  policy_e          policy_i,
  input  logic [NP-1:0]    hit_i,
  input  logic [NP*DW-1:0] wdata_i,
  output logic             upd_o,
  output logic [DW-1:0]    val_o,
  output logic             disagree_o
);

  logic          found;
  logic [DW-1:0] first_v;
  logic [DW-1:0] sum_v;
  logic [DW-1:0] and_v;
  logic [DW-1:0] max_v;
  logic          diff;

  // Fold all hitting writers; the lowest index is seen first
  always_comb begin
    found   = 1'b0;
    first_v = '0;
    sum_v   = '0;
    and_v   = '1;
    max_v   = '0;
    diff    = 1'b0;
    for (int p = 0; p < NP; p++) begin
      if (hit_i[p]) begin
        if (!found) begin
          first_v = wdata_i[p*DW +: DW];
          found   = 1'b1;
        end else if (wdata_i[p*DW +: DW] != first_v) begin
          diff = 1'b1;
        end
        sum_v = sum_v + wdata_i[p*DW +: DW];
        and_v = and_v & wdata_i[p*DW +: DW];
        if (wdata_i[p*DW +: DW] > max_v) max_v = wdata_i[p*DW +: DW];
      end
    end
  end

  always_comb begin
    upd_o      = found;
    val_o      = first_v;
    disagree_o = 1'b0;
    unique case (policy_i)
      POL_AGREE: begin
        upd_o      = found & ~diff;
        disagree_o = found & diff;
      end
      POL_SUM: val_o = sum_v;
      POL_AND: val_o = and_v;
      POL_MAX: val_o = max_v;
      POL_ANY, POL_RANK, POL_RSV6, POL_RSV7: val_o = first_v;
      default: val_o = first_v;
    endcase
  end

endmodule

// File: rtl/cwr_excl_check.sv
module cwr_excl_check #(
  parameter int NP    = 4,
  parameter int DEPTH = 8
) (
  input  logic [DEPTH*NP-1:0] wr_hit_i,
  input  logic [DEPTH*NP-1:0] rd_hit_i,
  output logic                wr_multi_o,
  output logic                rd_multi_o
);

  logic [DEPTH-1:0] wr_many;
  logic [DEPTH-1:0] rd_many;

  for (genvar c = 0; c < DEPTH; c++) begin : g_cell
    logic [NP-1:0] wh;
    logic [NP-1:0] rh;
    assign wh = wr_hit_i[c*NP +: NP];
    assign rh = rd_hit_i[c*NP +: NP];
    // More than one bit set: clearing the lowest set bit leaves something
    assign wr_many[c] = (wh & (wh - 1'b1)) != '0;
    assign rd_many[c] = (rh & (rh - 1'b1)) != '0;
  end

  assign wr_multi_o = |wr_many;
  assign rd_multi_o = |rd_many;

endmodule

// File: rtl/cwr_crcw_mem.sv
module cwr_crcw_mem
  import cwr_pkg::*;
#(
  parameter int NP    = 4,
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode_i,
  input  logic             excl_rd_i,
  input  logic             excl_wr_i,
  input  logic [NP-1:0]    req_vld_i,
  input  logic [NP-1:0]    req_we_i,
  input  logic [NP*AW-1:0] req_addr_i,
  input  logic [NP*DW-1:0] req_wdata_i,
  output logic [NP*DW-1:0] rsp_rdata_o,
  output logic             agree_err_o,
  output logic             wr_clash_o,
  output logic             rd_clash_o
);

  logic                rst_sn;
  policy_e             pol;
  logic [DW-1:0]       mem_q [DEPTH];
  logic [DEPTH*DW-1:0] mem_flat;
  logic [DEPTH*NP-1:0] wr_hit;
  logic [DEPTH*NP-1:0] rd_hit;
  logic [DEPTH-1:0]    cell_upd;
  logic [DEPTH-1:0]    cell_bad;
  logic [DW-1:0]       cell_val [DEPTH];
  logic                wr_multi;
  logic                rd_multi;
  logic                agree_err_d, agree_err_q;
  logic                wr_clash_d, wr_clash_q;
  logic                rd_clash_d, rd_clash_q;

  cwr_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  assign pol = policy_e'(mode_i);

  // Address decode: one hit bit per cell and port
  for (genvar c = 0; c < DEPTH; c++) begin : g_dec
    for (genvar p = 0; p < NP; p++) begin : g_port
      logic sel;
      assign sel = req_vld_i[p] && (req_addr_i[p*AW +: AW] == AW'(c));
      assign wr_hit[c*NP+p] = sel &  req_we_i[p];
      assign rd_hit[c*NP+p] = sel & ~req_we_i[p];
    end
  end

  // Per-cell collision resolution and storage with explicit enable
  for (genvar c = 0; c < DEPTH; c++) begin : g_cell
    cwr_cell_resolve #(
      .NP (NP),
      .DW (DW)
    ) u_res (
      .policy_i   (pol),
      .hit_i      (wr_hit[c*NP +: NP]),
      .wdata_i    (req_wdata_i),
      .upd_o      (cell_upd[c]),
      .val_o      (cell_val[c]),
      .disagree_o (cell_bad[c])
    );

    always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn)          mem_q[c] <= '0;
      else if (cell_upd[c]) mem_q[c] <= cell_val[c];
    end

    assign mem_flat[c*DW +: DW] = mem_q[c];
  end

  cwr_excl_check #(
    .NP    (NP),
    .DEPTH (DEPTH)
  ) u_excl (
    .wr_hit_i   (wr_hit),
    .rd_hit_i   (rd_hit),
    .wr_multi_o (wr_multi),
    .rd_multi_o (rd_multi)
  );

  // Flag next-state
  always_comb begin
    agree_err_d = agree_err_q | ((pol == POL_AGREE) & (|cell_bad));
    wr_clash_d  = excl_wr_i & wr_multi;
    rd_clash_d  = excl_rd_i & rd_multi;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      agree_err_q <= 1'b0;
      wr_clash_q  <= 1'b0;
      rd_clash_q  <= 1'b0;
    end else begin
      agree_err_q <= agree_err_d;
      wr_clash_q  <= wr_clash_d;
      rd_clash_q  <= rd_clash_d;
    end
  end

  // Read-before-write: returns stored contents, zero when not reading
  always_comb begin
    for (int p = 0; p < NP; p++) begin
      if (req_vld_i[p] && !req_we_i[p])
        rsp_rdata_o[p*DW +: DW] = mem_q[req_addr_i[p*AW +: AW]];
      else
        rsp_rdata_o[p*DW +: DW] = '0;
    end
  end

  assign agree_err_o = agree_err_q;
  assign wr_clash_o  = wr_clash_q;
  assign rd_clash_o  = rd_clash_q;

endmodule

// File: rtl/cwr_crcw_mem_chk.sv
module cwr_crcw_mem_chk #(
  parameter int NP    = 4,
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  parameter int AW    = 3
) (
  input logic                clk,
  input logic                rst_sn,
  input logic [2:0]          mode_i,
  input logic                excl_rd_i,
  input logic                excl_wr_i,
  input logic [NP-1:0]       req_vld_i,
  input logic [NP-1:0]       req_we_i,
  input logic [NP*AW-1:0]    req_addr_i,
  input logic [NP*DW-1:0]    req_wdata_i,
  input logic [DEPTH*DW-1:0] mem_flat,
  input logic                agree_err_o,
  input logic                wr_clash_o,
  input logic                rd_clash_o
);

  logic [AW-1:0] p0_addr_q;
  logic [DW-1:0] p0_cell;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) p0_addr_q <= '0;
    else         p0_addr_q <= req_addr_i[AW-1:0];
  end

  assign p0_cell = mem_flat[int'(p0_addr_q)*DW +: DW];

  // R4
  agree_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    agree_err_o |=> agree_err_o);

  // R12
  agree_src_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(agree_err_o) |-> ($past(mode_i) == 3'd0));

  // R10
  wr_clash_src_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_clash_o |-> $past(excl_wr_i));

  // R11
  rd_clash_src_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    rd_clash_o |-> $past(excl_rd_i));

  // R6
  rank_p0_wins_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (req_vld_i[0] && req_we_i[0] && mode_i == 3'd2)
      |=> (p0_cell == $past(req_wdata_i[DW-1:0])));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    ((req_vld_i & req_we_i) == '0) |=> $stable(mem_flat));

endmodule

bind cwr_crcw_mem cwr_crcw_mem_chk #(
  .NP    (NP),
  .DEPTH (DEPTH),
  .DW    (DW),
  .AW    (AW)
) u_chk (
  .clk         (clk),
  .rst_sn      (rst_sn),
  .mode_i      (mode_i),
  .excl_rd_i   (excl_rd_i),
  .excl_wr_i   (excl_wr_i),
  .req_vld_i   (req_vld_i),
  .req_we_i    (req_we_i),
  .req_addr_i  (req_addr_i),
  .req_wdata_i (req_wdata_i),
  .mem_flat    (mem_flat),
  .agree_err_o (agree_err_o),
  .wr_clash_o  (wr_clash_o),
  .rd_clash_o  (rd_clash_o)
);

// File: tb/cwr_crcw_mem_test.sv
`timescale 1ns/1ps
module cwr_crcw_mem_test;

  localparam int NP    = 4;
  localparam int DEPTH = 8;
  localparam int DW    = 8;
  localparam int AW    = 3;

  logic             clk;
  logic             rst_n;
  logic [2:0]       mode;
  logic             excl_rd, excl_wr;
  logic [NP-1:0]    vld, we;
  logic [NP*AW-1:0] addr;
  logic [NP*DW-1:0] wdata;
  logic [NP*DW-1:0] rdata;
  logic             agree_err, wr_clash, rd_clash;

  int n_chk  = 0;
  int n_fail = 0;
  int m_mem [DEPTH];
  bit m_err;
  bit done = 0;

  cwr_crcw_mem #(.NP(NP), .DEPTH(DEPTH), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .excl_rd_i(excl_rd),
    .excl_wr_i(excl_wr), .req_vld_i(vld), .req_we_i(we),
    .req_addr_i(addr), .req_wdata_i(wdata), .rsp_rdata_o(rdata),
    .agree_err_o(agree_err), .wr_clash_o(wr_clash), .rd_clash_o(rd_clash)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    vld = '0; we = '0; addr = '0; wdata = '0;
  endtask

  task automatic put(input int p, input bit w, input int a, input int d);
    vld[p] = 1'b1;
    we[p]  = w;
    addr[p*AW +: AW] = AW'(a);
    wdata[p*DW +: DW] = DW'(d);
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs cleared while reset is held
    chk(agree_err == 1'b0 && wr_clash == 1'b0 && rd_clash == 1'b0, "R1 flags in reset",
        int'({agree_err, wr_clash, rd_clash}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int c = 0; c < DEPTH; c++) m_mem[c] = 0;
    m_err = 1'b0;
  endtask

  // One clock: check reads now, predict, step, check flags, commit model
  task automatic cycle(input string tag);
    int  nxt [DEPTH];
    bit  e_wr, e_rd;
    #1;
    for (int p = 0; p < NP; p++) begin
      int exp;
      exp = (vld[p] && !we[p]) ? m_mem[addr[p*AW +: AW]] : 0;
      chk(int'(rdata[p*DW +: DW]) == exp, tag, int'(rdata[p*DW +: DW]), exp);
    end
    e_wr = 1'b0; e_rd = 1'b0;
    for (int c = 0; c < DEPTH; c++) begin
      int q[$];
      int nrd;
      nrd = 0;
      nxt[c] = m_mem[c];
      for (int p = 0; p < NP; p++) begin
        if (vld[p] && int'(addr[p*AW +: AW]) == c) begin
          if (we[p]) q.push_back(int'(wdata[p*DW +: DW]));
          else       nrd++;
        end
      end
      if (nrd > 1) e_rd = excl_rd;
      if (q.size() > 1) e_wr = excl_wr;
      if (q.size() > 0) begin
        case (mode)
          3'd0: begin
            bit same;
            same = 1'b1;
            foreach (q[i]) if (q[i] != q[0]) same = 1'b0;
            if (same) nxt[c] = q[0];
            else      m_err  = 1'b1;
          end
          3'd3: begin
            int s;
            s = 0;
            foreach (q[i]) s += q[i];
            nxt[c] = s % 256;
          end
          3'd4: begin
            int a;
            a = 255;
            foreach (q[i]) a &= q[i];
            nxt[c] = a;
          end
          3'd5: begin
            int m;
            m = 0;
            foreach (q[i]) if (q[i] > m) m = q[i];
            nxt[c] = m;
          end
          default: nxt[c] = q[0];
        endcase
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(agree_err == m_err, "R4/R12 agree_err", int'(agree_err), int'(m_err));
    chk(wr_clash == e_wr, "R10 wr_clash", int'(wr_clash), int'(e_wr));
    chk(rd_clash == e_rd, "R11 rd_clash", int'(rd_clash), int'(e_rd));
    for (int c = 0; c < DEPTH; c++) m_mem[c] = nxt[c];
    idle();
  endtask

  task automatic read_cell(input int a, input string tag);
    put(3, 1'b0, a, 0);
    cycle(tag);
  endtask

  initial begin
    mode = 3'd2; excl_rd = 1'b0; excl_wr = 1'b0;
    idle();
    @(negedge clk);
    do_reset();

    // R1: all cells read zero after reset
    for (int a = 0; a < DEPTH; a += NP) begin
      for (int p = 0; p < NP; p++) put(p, 1'b0, a + p, 0);
      cycle("R1");
    end

    // R3: distinct addresses all written
    mode = 3'd2;
    for (int p = 0; p < NP; p++) put(p, 1'b1, p + 4, 16 * p + 9);
    cycle("R3");
    for (int p = 0; p < NP; p++) put(p, 1'b0, p + 4, 0);
    cycle("R3");

    // R2: shared read with read-before-write on the same cell
    put(0, 1'b1, 1, 8'h5A);
    for (int p = 1; p < NP; p++) put(p, 1'b0, 1, 0);
    cycle("R2");
    for (int p = 0; p < NP; p++) put(p, 1'b0, 1, 0);
    cycle("R2");

    // R5: single winner is the lowest active index
    mode = 3'd1;
    put(1, 1'b1, 2, 11); put(2, 1'b1, 2, 22); put(3, 1'b1, 2, 33);
    cycle("R5");
    read_cell(2, "R5");

    // R6: rank policy and reserved codes
    for (int m = 0; m < 3; m++) begin
      mode = (m == 0) ? 3'd2 : 3'(5 + m);
      put(0, 1'b1, 3, 40 + m); put(3, 1'b1, 3, 90);
      cycle("R6");
      read_cell(3, "R6");
    end

    // R7: sum wraps
    mode = 3'd3;
    put(0, 1'b1, 4, 200); put(1, 1'b1, 4, 100); put(2, 1'b1, 4, 7); put(3, 1'b1, 4, 1);
    cycle("R7");
    read_cell(4, "R7");

    // R8: bitwise AND
    mode = 3'd4;
    put(0, 1'b1, 5, 8'hF3); put(2, 1'b1, 5, 8'h3E); put(3, 1'b1, 5, 8'h7B);
    cycle("R8");
    read_cell(5, "R8");

    // R9: unsigned maximum
    mode = 3'd5;
    put(0, 1'b1, 6, 17); put(1, 1'b1, 6, 250); put(2, 1'b1, 6, 128);
    cycle("R9");
    read_cell(6, "R9");

    // R12: collisions above left agree_err low
    chk(agree_err == 1'b0, "R12 no error outside mode 0", int'(agree_err), 0);

    // R4: agreement then disagreement
    mode = 3'd0;
    put(0, 1'b1, 7, 66); put(1, 1'b1, 7, 66); put(3, 1'b1, 7, 66);
    cycle("R4");
    read_cell(7, "R4");
    put(0, 1'b1, 7, 66); put(2, 1'b1, 7, 67);
    cycle("R4");
    read_cell(7, "R4");
    mode = 3'd1;
    repeat (3) cycle("R4");

    // R10 / R11: exclusive checks on and off
    excl_wr = 1'b1; excl_rd = 1'b1;
    put(0, 1'b1, 0, 1); put(1, 1'b1, 0, 2);
    cycle("R10");
    put(0, 1'b1, 0, 1); put(1, 1'b1, 1, 2);
    put(2, 1'b0, 3, 0); put(3, 1'b0, 4, 0);
    cycle("R10");
    put(2, 1'b0, 5, 0); put(3, 1'b0, 5, 0);
    cycle("R11");
    excl_wr = 1'b0; excl_rd = 1'b0;
    put(0, 1'b1, 0, 1); put(1, 1'b1, 0, 2);
    put(2, 1'b0, 5, 0); put(3, 1'b0, 5, 0);
    cycle("R10");

    // R1: reset clears sticky error and cells
    do_reset();
    for (int p = 0; p < NP; p++) put(p, 1'b0, p + 4, 0);
    cycle("R1");

    // Random mix with frequent collisions
    for (int n = 0; n < 400; n++) begin
      mode    = 3'($urandom_range(0, 7));
      excl_rd = 1'($urandom_range(0, 1));
      excl_wr = 1'($urandom_range(0, 1));
      for (int p = 0; p < NP; p++) begin
        if ($urandom_range(0, 3) != 0)
          put(p, 1'($urandom_range(0, 1)), $urandom_range(0, 2), $urandom_range(0, 255));
      end
      cycle("R2 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule